// File: doc/BRIEF.md
# Flash Identification and Query Read Responder

This block produces read data for a parallel NOR flash bank while the command logic has placed it in either identification mode or query mode. A bank is `BANK_W` bytes wide. It is built from devices that are each `DEV_W` bytes wide, and each device may be able to run wider, up to `MAX_DEV_W` bytes. The responder takes the byte offset of a bus read and rescales it into the index that a single device would see. It then fetches either one byte of the query table or one of the two identification words. From that it builds the answer every device on the bank would drive, and places the copies side by side across the bank.

A bus read may be wider than the bank. In that case the read is served as several bank-sized lookups at consecutive bank offsets, packed from the least significant byte upward. The result appears one clock after the read strobe. Command decoding, status reads and array reads live elsewhere.

Top module: `fidq_responder`

## Requirements
- R1: After a clock edge with `rst_n` low, `rsp_valid` is 0 and `rsp_data` is all zero.
- R2: `rsp_valid` is 1 in exactly the cycle after each cycle with `rd_en` high. `rsp_data` takes the new answer in that cycle and keeps it unchanged until the next read.
- R3: The device index of a lookup is the lookup's byte offset shifted right by log2(BANK_W) + log2(MAX_DEV_W) − log2(DEV_W).
- R4: In query mode (`rd_query`=1), an index of 82 (0x52) or more yields a zero byte.
- R5: The query table holds 0x51, 0x52 and 0x59 at indices 0x10, 0x11 and 0x12. It holds 0x01 at 0x13 and 0x00 at 0x14, `SIZE_LOG2` at 0x27 and 0x01 at 0x2C. Every other index below 0x52 reads zero.
- R6: In query mode, a device with DEV_W=1 and MAX_DEV_W>1 answers with the table byte copied into every byte of its maximum width, not zero-padded. Any other configuration with DEV_W≠MAX_DEV_W, or one with BANK_W>4, answers zero. When DEV_W=MAX_DEV_W, the table byte sits in device byte 0 and the upper device bytes are zero.
- R7: Bank byte k of a lookup equals byte (k mod DEV_W) of the per-device answer.
- R8: In identification mode (`rd_query`=0), only the low 8 bits of the index are used. Index 0 gives `MFR_ID` and index 1 gives `DEV_ID`, each 16 bits wide and placed least significant byte first in the device answer with any higher device bytes zero. All other indices give zero.
- R9: `rd_size` gives the read width as log2 of the byte count, limited to `ACC_W` bytes. Bus bytes [s·BANK_W, (s+1)·BANK_W) hold the lookup at byte offset `rd_addr` + s·BANK_W.
- R10: Bus bytes at or above the requested byte count are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_query | input | 1 | 1 = query table mode, 0 = identification mode |
| rd_addr | input | ADDR_W | Bus byte offset of the read |
| rd_size | input | 2 | log2 of the read width in bytes |
| rsp_valid | output | 1 | Response present, one cycle after `rd_en` |
| rsp_data | output | 8*ACC_W | Response bytes, lowest address in the low byte |

## Verification
The hardest behaviour to reach is the interaction between address rescaling and wide-read splitting. This happens when the second bank-sized lookup of a read falls on a different device index than the first, or crosses the 0x52 table boundary. The bench drives four instances with different bank, device and maximum widths from the same stimulus, so that one offset lands on different indices in each. It also aims directed offsets at the boundary index and at the "QRY" bytes for each instance's shift amount. Random offsets then cover the area on both sides of the table end at all read sizes.

// File: rtl/fidq_pkg.sv
// Package: shared constants and the computed query table for the
// identification/query responder. Assumes table indices fit in 8 bits.
package fidq_pkg;

    localparam int QTAB_DEPTH = 82;

    // Query table contents; entries not listed read as zero.
    function automatic logic [7:0] qtab_byte(input logic [7:0] idx,
                                             input logic [7:0] size_log2);
        logic [7:0] v;
        case (idx)
            8'h10:   v = 8'h51;
            8'h11:   v = 8'h52;
            8'h12:   v = 8'h59;
            8'h13:   v = 8'h01;
            8'h14:   v = 8'h00;
            8'h27:   v = size_log2;
            8'h2C:   v = 8'h01;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/fidq_index_scaler.sv
// Module: converts a bus byte offset plus a slice offset into the index a
// single device sees. Assumes all widths are powers of two and
// DEV_W <= MAX_DEV_W.
module fidq_index_scaler #(
    parameter int ADDR_W    = 16,
    parameter int BANK_W    = 4,
    parameter int DEV_W     = 1,
    parameter int MAX_DEV_W = 2,
    parameter int SLICE     = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W:0]   idx
);
    localparam int SHIFT = $clog2(BANK_W) + $clog2(MAX_DEV_W) - $clog2(DEV_W);
    localparam logic [ADDR_W:0] SLICE_OFS = (ADDR_W+1)'(SLICE * BANK_W);

    logic [ADDR_W:0] byte_ofs;

    // Add the slice offset, one bit wider so the sum cannot wrap.
    always_comb begin
        byte_ofs = {1'b0, addr} + SLICE_OFS;
        idx      = byte_ofs >> SHIFT;
    end

endmodule

// File: rtl/fidq_query_rom.sv
// Module: range-checked lookup into the query table. Indices at or beyond
// the table depth return zero. Assumes IDX_W >= 8.
module fidq_query_rom #(
    parameter int         IDX_W     = 17,
    parameter logic [7:0] SIZE_LOG2 = 8'd23
) (
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       tbyte
);
    import fidq_pkg::*;

    logic in_range;

    // Compare the full index so high offsets never alias into the table.
    always_comb begin
        in_range = (idx < IDX_W'(QTAB_DEPTH));
        tbyte    = in_range ? qtab_byte(idx[7:0], SIZE_LOG2) : 8'h00;
    end

endmodule

// File: rtl/fidq_lane_builder.sv
// Module: builds one bank-wide answer for one device index: the
// per-device answer (query byte or ID word) and its copies across all
// device slots of the bank. Assumes DEV_W divides BANK_W.
module fidq_lane_builder #(
    parameter int          IDX_W     = 17,
    parameter int          BANK_W    = 4,
    parameter int          DEV_W     = 1,
    parameter int          MAX_DEV_W = 2,
    parameter logic [15:0] MFR_ID    = 16'h0089,
    parameter logic [15:0] DEV_ID    = 16'h0018,
    parameter logic [7:0]  SIZE_LOG2 = 8'd23
) (
    input  logic                  query,
    input  logic [IDX_W-1:0]      idx,
    output logic [8*BANK_W-1:0]   bank_val
);
    localparam int IDW = (DEV_W > 2) ? DEV_W : 2;

    logic [7:0]             q_byte;
    logic [8*MAX_DEV_W-1:0] q_wide;
    logic [8*IDW-1:0]       id_wide;
    logic [8*DEV_W-1:0]     dev_val;

    fidq_query_rom #(
        .IDX_W     (IDX_W),
        .SIZE_LOG2 (SIZE_LOG2)
    ) u_rom (
        .idx   (idx),
        .tbyte (q_byte)
    );

    // Shape the query byte to the device's maximum width.
    generate
        if (DEV_W == MAX_DEV_W) begin : g_native
            always_comb q_wide = (8*MAX_DEV_W)'(q_byte);
        end else if (DEV_W == 1 && BANK_W <= 4) begin : g_narrow
            always_comb q_wide = {MAX_DEV_W{q_byte}};
        end else begin : g_unsup
            always_comb q_wide = '0;
        end
    endgenerate

    // Pick the identification word from the low index byte.
    always_comb begin
        case (idx[7:0])
            8'd0:    id_wide = (8*IDW)'(MFR_ID);
            8'd1:    id_wide = (8*IDW)'(DEV_ID);
            default: id_wide = '0;
        endcase
    end

    // Per-device answer: low DEV_W bytes of the selected source.
    always_comb begin
        dev_val = query ? q_wide[8*DEV_W-1:0] : id_wide[8*DEV_W-1:0];
    end

    // Copy the device answer into every device slot of the bank.
    generate
        for (genvar k = 0; k < BANK_W; k++) begin : g_rep
            assign bank_val[8*k +: 8] = dev_val[8*(k % DEV_W) +: 8];
        end
    endgenerate

endmodule

// File: rtl/fidq_responder.sv
// Module: top of the identification/query read responder. Splits a bus
// read into bank-wide lookups, masks bytes beyond the requested size and
// registers the result one clock after the strobe. Assumes power-of-two
// widths, DEV_W <= MAX_DEV_W, DEV_W <= BANK_W <= ACC_W <= 8.
module fidq_responder #(
    parameter int          ADDR_W    = 16,
    parameter int          BANK_W    = 4,
    parameter int          DEV_W     = 1,
    parameter int          MAX_DEV_W = 2,
    parameter int          ACC_W     = 4,
    parameter logic [15:0] MFR_ID    = 16'h0089,
    parameter logic [15:0] DEV_ID    = 16'h0018,
    parameter logic [7:0]  SIZE_LOG2 = 8'd23
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic                 rd_query,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic [1:0]           rd_size,
    output logic                 rsp_valid,
    output logic [8*ACC_W-1:0]   rsp_data
);
    localparam int NSLICE = ACC_W / BANK_W;
    localparam int ACC_LG = $clog2(ACC_W);
    localparam int IDX_W  = ADDR_W + 1;

    logic [8*ACC_W-1:0] slice_data;
    logic [8*ACC_W-1:0] masked;
    int unsigned        nbytes;

    // One scaler and one lane builder per bank-wide slice of the read.
    generate
        for (genvar s = 0; s < NSLICE; s++) begin : g_slice
            logic [IDX_W-1:0]    idx_s;
            logic [8*BANK_W-1:0] val_s;

            fidq_index_scaler #(
                .ADDR_W    (ADDR_W),
                .BANK_W    (BANK_W),
                .DEV_W     (DEV_W),
                .MAX_DEV_W (MAX_DEV_W),
                .SLICE     (s)
            ) u_scl (
                .addr (rd_addr),
                .idx  (idx_s)
            );

            fidq_lane_builder #(
                .IDX_W     (IDX_W),
                .BANK_W    (BANK_W),
                .DEV_W     (DEV_W),
                .MAX_DEV_W (MAX_DEV_W),
                .MFR_ID    (MFR_ID),
                .DEV_ID    (DEV_ID),
                .SIZE_LOG2 (SIZE_LOG2)
            ) u_lane (
                .query    (rd_query),
                .idx      (idx_s),
                .bank_val (val_s)
            );

            assign slice_data[8*BANK_W*s +: 8*BANK_W] = val_s;
        end
    endgenerate

    // Clamp the requested size and zero the bytes beyond it.
    always_comb begin
        int unsigned lg;
        lg     = (int'(rd_size) > ACC_LG) ? ACC_LG : int'(rd_size);
        nbytes = 1 << lg;
        for (int j = 0; j < ACC_W; j++) begin
            masked[8*j +: 8] = (j < nbytes) ? slice_data[8*j +: 8] : 8'h00;
        end
    end

    // Register the response; hold the data between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rd_en;
            if (rd_en) begin
                rsp_data <= masked;
            end
        end
    end

endmodule

// File: rtl/fidq_responder_chk.sv
// Module: assertion checker for fidq_responder, attached by bind.
// Relates the read strobe and request fields to the registered response.
module fidq_responder_chk #(
    parameter int ADDR_W    = 16,
    parameter int BANK_W    = 4,
    parameter int DEV_W     = 1,
    parameter int MAX_DEV_W = 2,
    parameter int ACC_W     = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rd_en,
    input logic                 rd_query,
    input logic [ADDR_W-1:0]    rd_addr,
    input logic [1:0]           rd_size,
    input logic                 rsp_valid,
    input logic [8*ACC_W-1:0]   rsp_data
);
    localparam int SHIFT   = $clog2(BANK_W) + $clog2(MAX_DEV_W) - $clog2(DEV_W);
    localparam int BANK_LG = $clog2(BANK_W);

    logic [ADDR_W:0] base_idx;
    assign base_idx = {1'b0, rd_addr} >> SHIFT;

    p_valid_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rsp_valid);

    p_no_valid_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rsp_valid);

    p_hold_between_reads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rsp_data));

    p_query_out_of_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_query && rd_size == 2'd0 && base_idx >= (ADDR_W+1)'(82))
        |=> (rsp_data == '0));

    p_id_other_index_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_query && rd_size == 2'd0 && base_idx[7:0] >= 8'd2)
        |=> (rsp_data == '0));

    generate
        if (ACC_W >= 2) begin : g_mask
            p_upper_bytes_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_en && rd_size == 2'd0) |=> (rsp_data[8*ACC_W-1:8] == '0));
        end
        if (BANK_W >= 2*DEV_W) begin : g_rep
            p_device_copies_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_en && rd_size == 2'(BANK_LG))
                |=> (rsp_data[8*DEV_W-1:0] == rsp_data[16*DEV_W-1:8*DEV_W]));
        end
    endgenerate

endmodule

bind fidq_responder fidq_responder_chk #(
    .ADDR_W    (ADDR_W),
    .BANK_W    (BANK_W),
    .DEV_W     (DEV_W),
    .MAX_DEV_W (MAX_DEV_W),
    .ACC_W     (ACC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_query  (rd_query),
    .rd_addr   (rd_addr),
    .rd_size   (rd_size),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
);

// File: tb/fidq_responder_tb_top.sv
// Bench: drives four responder configurations with the same reads and
// compares each against a model computed from the requirements.
module fidq_responder_tb_top;

    localparam logic [15:0] MFR = 16'h0089;
    localparam logic [15:0] DID = 16'h0018;
    localparam logic [7:0]  SZL = 8'd23;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        rd_query = 1'b0;
    logic [15:0] rd_addr = '0;
    logic [1:0]  rd_size = '0;

    logic        v0, v1, v2, v3;
    logic [31:0] d0, d1, d2, d3;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    // bank/dev/max = 4/1/2
    fidq_responder #(.BANK_W(4), .DEV_W(1), .MAX_DEV_W(2), .ACC_W(4),
        .MFR_ID(MFR), .DEV_ID(DID), .SIZE_LOG2(SZL)) dut_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_query(rd_query),
        .rd_addr(rd_addr), .rd_size(rd_size), .rsp_valid(v0), .rsp_data(d0));
    // 2/2/2
    fidq_responder #(.BANK_W(2), .DEV_W(2), .MAX_DEV_W(2), .ACC_W(4),
        .MFR_ID(MFR), .DEV_ID(DID), .SIZE_LOG2(SZL)) dut_b (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_query(rd_query),
        .rd_addr(rd_addr), .rd_size(rd_size), .rsp_valid(v1), .rsp_data(d1));
    // 4/2/2
    fidq_responder #(.BANK_W(4), .DEV_W(2), .MAX_DEV_W(2), .ACC_W(4),
        .MFR_ID(MFR), .DEV_ID(DID), .SIZE_LOG2(SZL)) dut_c (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_query(rd_query),
        .rd_addr(rd_addr), .rd_size(rd_size), .rsp_valid(v2), .rsp_data(d2));
    // 4/2/4: unsupported mismatch, query answers zero
    fidq_responder #(.BANK_W(4), .DEV_W(2), .MAX_DEV_W(4), .ACC_W(4),
        .MFR_ID(MFR), .DEV_ID(DID), .SIZE_LOG2(SZL)) dut_d (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_query(rd_query),
        .rd_addr(rd_addr), .rd_size(rd_size), .rsp_valid(v3), .rsp_data(d3));

    function automatic int lg2(input int x);
        int r = 0;
        while ((1 << r) < x) r++;
        return r;
    endfunction

    function automatic logic [7:0] tab(input int idx);
        case (idx)
            16: return 8'h51;
            17: return 8'h52;
            18: return 8'h59;
            19: return 8'h01;
            39: return SZL;
            44: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    // Expected bus word for one configuration.
    function automatic logic [31:0] model(input int bank, input int dev, input int mx,
                                          input bit q, input int addr, input int size);
        logic [31:0] r = '0;
        int nb = 1 << size;
        int sh = lg2(bank) + lg2(mx) - lg2(dev);
        if (nb > 4) nb = 4;
        for (int j = 0; j < 4; j++) begin
            int s = j / bank;
            int d = (j % bank) % dev;
            int idx = (addr + s * bank) >> sh;
            logic [7:0] b = 8'h00;
            if (j < nb) begin
                if (q) begin
                    if (idx < 82 && (dev == mx || (dev == 1 && bank <= 4))) begin
                        if (dev != mx || d == 0) b = tab(idx);
                    end
                end else begin
                    logic [15:0] w = ((idx & 255) == 0) ? MFR :
                                     ((idx & 255) == 1) ? DID : 16'h0000;
                    if (d == 0) b = w[7:0];
                    else if (d == 1) b = w[15:8];
                end
            end
            r[8*j +: 8] = b;
        end
        return r;
    endfunction

    task automatic cmp(input string tag, input string who, input logic valid,
                       input logic expv, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (valid !== expv || act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: valid=%0b data=%08h expected valid=%0b data=%08h",
                     tag, who, valid, act, expv, exp);
        end
    endtask

    logic [31:0] e0, e1, e2, e3;

    // One read: drive at a falling edge, check at the next falling edge.
    task automatic do_read(input bit q, input int addr, input int size, input string tag);
        @(negedge clk);
        rd_en    = 1'b1;
        rd_query = q;
        rd_addr  = 16'(addr);
        rd_size  = 2'(size);
        e0 = model(4, 1, 2, q, addr, size);
        e1 = model(2, 2, 2, q, addr, size);
        e2 = model(4, 2, 2, q, addr, size);
        e3 = model(4, 2, 4, q, addr, size);
        @(negedge clk);
        rd_en = 1'b0;
        cmp(tag, "cfg 4/1/2", v0, 1'b1, d0, e0);
        cmp(tag, "cfg 2/2/2", v1, 1'b1, d1, e1);
        cmp(tag, "cfg 4/2/2", v2, 1'b1, d2, e2);
        cmp(tag, "cfg 4/2/4", v3, 1'b1, d3, e3);
    endtask

    // Idle cycle with changed inputs: output must hold (R2).
    task automatic idle_hold();
        rd_query = ~rd_query;
        rd_addr  = rd_addr ^ 16'h0055;
        @(negedge clk);
        cmp("R2", "cfg 4/1/2 hold", v0, 1'b0, d0, e0);
        cmp("R2", "cfg 2/2/2 hold", v1, 1'b0, d1, e1);
        cmp("R2", "cfg 4/2/2 hold", v2, 1'b0, d2, e2);
        cmp("R2", "cfg 4/2/4 hold", v3, 1'b0, d3, e3);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        cmp("R1", "cfg 4/1/2", v0, 1'b0, d0, 32'h0);
        cmp("R1", "cfg 2/2/2", v1, 1'b0, d1, 32'h0);
        cmp("R1", "cfg 4/2/2", v2, 1'b0, d2, 32'h0);
        cmp("R1", "cfg 4/2/4", v3, 1'b0, d3, 32'h0);
        rst_n = 1'b1;

        // R8: identification indices 0, 1, 2 and aliased high index
        for (int i = 0; i < 3; i++) begin
            do_read(1'b0, i << 3, 2, "R8");
            do_read(1'b0, i << 2, 2, "R8");
            do_read(1'b0, i << 1, 1, "R8");
        end
        do_read(1'b0, 256 << 3, 0, "R8");
        idle_hold();
        // R5: "QRY" and other entries at each configuration's shift
        for (int i = 16; i < 20; i++) begin
            do_read(1'b1, i << 3, 2, "R5");
            do_read(1'b1, i << 1, 1, "R5");
            do_read(1'b1, i << 2, 2, "R5");
        end
        do_read(1'b1, 39 << 3, 0, "R5");
        do_read(1'b1, 39 << 2, 2, "R5");
        do_read(1'b1, 44 << 1, 1, "R5");
        // R6: narrow-mode copies and unsupported configuration
        do_read(1'b1, 17 << 3, 2, "R6");
        // R4: table boundary 81/82 and slices straddling it
        do_read(1'b1, 81 << 3, 0, "R4");
        do_read(1'b1, 82 << 3, 0, "R4");
        do_read(1'b1, 81 << 1, 2, "R4");
        do_read(1'b1, 81 << 2, 2, "R4");
        idle_hold();
        // R9/R10: size clamp and partial widths
        do_read(1'b1, 16 << 1, 3, "R9");
        do_read(1'b0, 0, 3, "R9");
        do_read(1'b1, 16 << 3, 0, "R10");
        do_read(1'b0, 4, 1, "R10");
        // R7: bank replication at full bank width
        do_read(1'b0, 0, 2, "R7");
        do_read(1'b1, 18 << 2, 2, "R7");
        // R3: random offsets, modes and sizes
        for (int n = 0; n < 400; n++) begin
            do_read(1'($urandom % 2), int'($urandom % 16'h0300), int'($urandom % 4), "R3");
            if (($urandom % 5) == 0) idle_hold();
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule